// File: doc/BRIEF.md
# Half-Bridge Fault Protection Controller

This block sits between the command word of a three-channel half-bridge driver and its six gate enables. Each channel has a high-side and a low-side request. The block passes each request to its gate only when no protection condition blocks it. The conditions are a cross-conduction request, an overcurrent that lasts too long, supply overvoltage or undervoltage, and thermal shutdown. It keeps sticky fault flags, and a one-cycle status-clear pulse releases them.

Overcurrent is timed per channel. The delay (short or long, in clock cycles) is chosen by a command bit. The choice is fixed at the moment the timer starts. Overvoltage lockout does not latch: the programmed outputs come back as soon as the supply recovers. Shoot-through, overcurrent and thermal shutdown latch the drivers off until a status clear.

Top module: `hb_guard`

## Requirements
- R1: During reset every gate output is 0 whatever the requests, and after reset all status flags read 0.
- R2: With no fault present, `gate_hs[i]` equals `hs_req[i]` and `gate_ls[i]` equals `ls_req[i]` in the same cycle. Bit i is channel i.
- R3: When `hs_req[i]` and `ls_req[i]` are both 1, both gates of channel i are 0 in that cycle. `stat_shoot` is 1 after the next rising edge.
- R4: After a shoot-through, both gates of that channel stay 0 until a rising edge samples `clr_pulse` = 1 while the channel no longer requests both sides.
- R5: If `oc_cmp[i]` is sampled 1 at D consecutive rising edges, channel i latches off at the D-th edge and `stat_oc` becomes 1. D is SHORT_DLY when `oc_fast` = 1 and LONG_DLY when `oc_fast` = 0.
- R6: If `oc_cmp[i]` is sampled 0 at any edge before the delay expires, the count restarts from zero.
- R7: The delay in force is the one selected by `oc_fast` at the edge where the timer starts. Later changes of `oc_fast` do not alter a running timer.
- R8: A channel latched off by overcurrent stays off, and `stat_oc` stays 1, until an edge samples `clr_pulse` = 1.
- R9: `ov_flag` sets the sticky `stat_psf` at the next edge. When `ov_lock_en` = 1, all gates are 0 while `ov_flag` = 1, and they return to the requested states once it drops. When `ov_lock_en` = 0, the gates are unaffected.
- R10: While `uv_flag` = 1 all gates are 0, and `stat_psf` is set.
- R11: Any `tw_cmp` bit sets the sticky `stat_tw` without changing the gates. A clear pulse resets it only when no `tw_cmp` bit is active.
- R12: Any `tsd_cmp` bit forces all gates to 0 at once and latches them off. They are released only by a clear pulse sampled while all `tsd_cmp` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_req | input | NCH | High-side on requests |
| ls_req | input | NCH | Low-side on requests |
| oc_fast | input | 1 | 1 selects the short overcurrent delay |
| ov_lock_en | input | 1 | 1 turns all gates off during overvoltage |
| clr_pulse | input | 1 | Status clear (one cycle) |
| oc_cmp | input | NCH | Per-channel overcurrent comparators |
| ov_flag | input | 1 | Supply overvoltage |
| uv_flag | input | 1 | Supply undervoltage |
| tw_cmp | input | NCH | Per-channel thermal warning comparators |
| tsd_cmp | input | NCH | Per-channel thermal shutdown comparators |
| gate_hs | output | NCH | High-side gate enables |
| gate_ls | output | NCH | Low-side gate enables |
| stat_shoot | output | 1 | Sticky shoot-through flag |
| stat_oc | output | 1 | Sticky overcurrent flag |
| stat_psf | output | 1 | Sticky supply fault flag |
| stat_tw | output | 1 | Sticky thermal warning flag |

## Verification
The assertions check on every cycle the properties that hold in any state:
- the two gates of one channel are never on together;
- no gate is on without its request;
- supply faults force the gates off;
- each fault flag stays set until a clear, and is set after its cause.

Only the bench scenarios can show the cycle-exact overcurrent delays. They also show the timer restart after a dropout, the freezing of the delay selection, the release sequences after a clear, and the return of the outputs after overvoltage.

// File: rtl/hb_guard_pkg.sv
package hb_guard_pkg;

    typedef struct packed {
        logic shoot;
        logic oc;
        logic psf;
        logic tw;
    } hb_flags_t;

    // picks the overcurrent delay in cycles from the select bit
    function automatic int oc_pick(input int short_d, input int long_d, input logic fast);
        return fast ? short_d : long_d;
    endfunction

endpackage

// File: rtl/hb_sticky.sv
module hb_sticky #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q
);
    // set has priority over clear so a persisting cause keeps the flag
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            for (int b = 0; b < W; b++) begin
                if (set_i[b])   q[b] <= 1'b1;
                else if (clr_i) q[b] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hb_oc_timer.sv
module hb_oc_timer
    import hb_guard_pkg::*;
#(
    parameter int SHORT_DLY = 3,
    parameter int LONG_DLY  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp,
    input  logic fast_sel,
    input  logic clr,
    output logic trip
);
    localparam int CW = $clog2(LONG_DLY + 1);

    logic          run;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_q;
    logic [CW-1:0] start_lim;
    logic [CW-1:0] lim_eff;
    logic [CW-1:0] cnt_nx;
    logic          hit;

    always_comb begin
        start_lim = CW'(oc_pick(SHORT_DLY, LONG_DLY, fast_sel));
        lim_eff   = run ? lim_q : start_lim;
        cnt_nx    = run ? cnt + CW'(1) : CW'(1);
        hit       = cmp && !trip && (cnt_nx == lim_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trip  <= 1'b0;
            run   <= 1'b0;
            cnt   <= '0;
            lim_q <= '0;
        end else begin
            if (hit)      trip <= 1'b1;
            else if (clr) trip <= 1'b0;

            if (cmp && !trip && !hit) begin
                run <= 1'b1;
                cnt <= cnt_nx;
                if (!run) lim_q <= start_lim;   // delay frozen at start
            end else begin
                run <= 1'b0;
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/hb_gate.sv
module hb_gate (
    input  logic hs_req,
    input  logic ls_req,
    input  logic shoot_lat,
    input  logic oc_lat,
    input  logic glob_off,
    output logic hs_on,
    output logic ls_on,
    output logic both
);
    logic block;

    always_comb begin
        both  = hs_req & ls_req;
        block = both | shoot_lat | oc_lat | glob_off;
        hs_on = hs_req & ~block;
        ls_on = ls_req & ~block;
    end
endmodule

// File: rtl/hb_guard.sv
module hb_guard
    import hb_guard_pkg::*;
#(
    parameter int NCH       = 3,
    parameter int SHORT_DLY = 3,
    parameter int LONG_DLY  = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] hs_req,
    input  logic [NCH-1:0] ls_req,
    input  logic           oc_fast,
    input  logic           ov_lock_en,
    input  logic           clr_pulse,
    input  logic [NCH-1:0] oc_cmp,
    input  logic           ov_flag,
    input  logic           uv_flag,
    input  logic [NCH-1:0] tw_cmp,
    input  logic [NCH-1:0] tsd_cmp,
    output logic [NCH-1:0] gate_hs,
    output logic [NCH-1:0] gate_ls,
    output logic           stat_shoot,
    output logic           stat_oc,
    output logic           stat_psf,
    output logic           stat_tw
);
    logic [NCH-1:0] both;
    logic [NCH-1:0] shoot_lat;
    logic [NCH-1:0] oc_lat;
    logic           psf_lat;
    logic           tw_lat;
    logic           tsd_lat;
    logic           glob_off;
    hb_flags_t      flags;

    assign glob_off = rst | uv_flag | (ov_flag & ov_lock_en) | tsd_lat | (|tsd_cmp);

    hb_sticky #(.W(NCH)) u_shoot (
        .clk(clk), .rst(rst), .set_i(both), .clr_i(clr_pulse), .q(shoot_lat)
    );

    hb_sticky #(.W(1)) u_psf (
        .clk(clk), .rst(rst), .set_i(ov_flag | uv_flag), .clr_i(clr_pulse), .q(psf_lat)
    );

    hb_sticky #(.W(1)) u_tw (
        .clk(clk), .rst(rst), .set_i(|tw_cmp), .clr_i(clr_pulse), .q(tw_lat)
    );

    hb_sticky #(.W(1)) u_tsd (
        .clk(clk), .rst(rst), .set_i(|tsd_cmp), .clr_i(clr_pulse), .q(tsd_lat)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        hb_oc_timer #(
            .SHORT_DLY(SHORT_DLY),
            .LONG_DLY (LONG_DLY)
        ) u_oc (
            .clk     (clk),
            .rst     (rst),
            .cmp     (oc_cmp[ch]),
            .fast_sel(oc_fast),
            .clr     (clr_pulse),
            .trip    (oc_lat[ch])
        );

        hb_gate u_gate (
            .hs_req   (hs_req[ch]),
            .ls_req   (ls_req[ch]),
            .shoot_lat(shoot_lat[ch]),
            .oc_lat   (oc_lat[ch]),
            .glob_off (glob_off),
            .hs_on    (gate_hs[ch]),
            .ls_on    (gate_ls[ch]),
            .both     (both[ch])
        );
    end

    always_comb begin
        flags.shoot = |shoot_lat;
        flags.oc    = |oc_lat;
        flags.psf   = psf_lat;
        flags.tw    = tw_lat;
    end

    assign stat_shoot = flags.shoot;
    assign stat_oc    = flags.oc;
    assign stat_psf   = flags.psf;
    assign stat_tw    = flags.tw;
endmodule

// File: rtl/hb_guard_chk.sv
module hb_guard_chk #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] hs_req,
    input logic [NCH-1:0] ls_req,
    input logic           ov_flag,
    input logic           uv_flag,
    input logic           ov_lock_en,
    input logic           clr_pulse,
    input logic [NCH-1:0] gate_hs,
    input logic [NCH-1:0] gate_ls,
    input logic           stat_shoot,
    input logic           stat_oc,
    input logic           stat_psf,
    input logic           stat_tw
);
    AST_NO_CROSS_COND: assert property (@(posedge clk) disable iff (rst) (gate_hs & gate_ls) == '0); // R3
    AST_SHOOT_FLAGGED: assert property (@(posedge clk) disable iff (rst) (|(hs_req & ls_req)) |=> stat_shoot); // R3
    AST_GATE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst) ((gate_hs & ~hs_req) | (gate_ls & ~ls_req)) == '0); // R2
    AST_OV_LOCKOUT: assert property (@(posedge clk) disable iff (rst) (ov_flag && ov_lock_en) |-> (gate_hs == '0 && gate_ls == '0)); // R9
    AST_PSF_SET: assert property (@(posedge clk) disable iff (rst) (ov_flag || uv_flag) |=> stat_psf); // R9
    AST_UV_OFF: assert property (@(posedge clk) disable iff (rst) uv_flag |-> (gate_hs == '0 && gate_ls == '0)); // R10
    AST_OC_HELD: assert property (@(posedge clk) disable iff (rst) (stat_oc && !clr_pulse) |=> stat_oc); // R8
    AST_TW_HELD: assert property (@(posedge clk) disable iff (rst) (stat_tw && !clr_pulse) |=> stat_tw); // R11
endmodule

bind hb_guard hb_guard_chk #(.NCH(NCH)) u_hb_guard_chk (
    .clk(clk), .rst(rst), .hs_req(hs_req), .ls_req(ls_req),
    .ov_flag(ov_flag), .uv_flag(uv_flag), .ov_lock_en(ov_lock_en),
    .clr_pulse(clr_pulse), .gate_hs(gate_hs), .gate_ls(gate_ls),
    .stat_shoot(stat_shoot), .stat_oc(stat_oc), .stat_psf(stat_psf),
    .stat_tw(stat_tw)
);

// File: tb/hb_guard_bench.sv
`timescale 1ns/1ps
module hb_guard_bench;
    localparam int NCH = 3;
    localparam int SD  = 3;
    localparam int LD  = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic [NCH-1:0] hs_req, ls_req, oc_cmp, tw_cmp, tsd_cmp;
    logic           oc_fast, ov_lock_en, clr_pulse, ov_flag, uv_flag;
    logic [NCH-1:0] gate_hs, gate_ls;
    logic           stat_shoot, stat_oc, stat_psf, stat_tw;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    hb_guard #(.NCH(NCH), .SHORT_DLY(SD), .LONG_DLY(LD)) u_hb_guard (
        .clk(clk), .rst(rst), .hs_req(hs_req), .ls_req(ls_req),
        .oc_fast(oc_fast), .ov_lock_en(ov_lock_en), .clr_pulse(clr_pulse),
        .oc_cmp(oc_cmp), .ov_flag(ov_flag), .uv_flag(uv_flag),
        .tw_cmp(tw_cmp), .tsd_cmp(tsd_cmp), .gate_hs(gate_hs), .gate_ls(gate_ls),
        .stat_shoot(stat_shoot), .stat_oc(stat_oc), .stat_psf(stat_psf),
        .stat_tw(stat_tw)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // advance past one rising edge; inputs change here
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // observe outputs mid-cycle
    task automatic look();
        @(negedge clk);
    endtask

    task automatic clear();
        clr_pulse = 1'b1;
        step();
        clr_pulse = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R1..R12 actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; hs_req = '1; ls_req = '0; oc_cmp = '0; tw_cmp = '0; tsd_cmp = '0;
        oc_fast = 1'b1; ov_lock_en = 1'b1; clr_pulse = 1'b0; ov_flag = 1'b0; uv_flag = 1'b0;
        repeat (3) step();
        look();
        chk("R1 gate_hs in reset", gate_hs, 0);
        hs_req = '0;
        step();
        rst = 1'b0;
        step();
        look();
        chk("R1 flags after reset", {stat_shoot, stat_oc, stat_psf, stat_tw}, 0);
        chk("R1 gates after reset", {gate_hs, gate_ls}, 0);

        // R2, R3: every request pattern
        for (int v = 0; v < 64; v++) begin
            logic [NCH-1:0] h, l, b;
            h = v[2:0]; l = v[5:3]; b = h & l;
            hs_req = h; ls_req = l;
            look();
            chk("R2/R3 gate_hs", gate_hs, h & ~b);
            chk("R2/R3 gate_ls", gate_ls, l & ~b);
            step();
            look();
            chk("R3 stat_shoot", stat_shoot, |b);
            hs_req = '0; ls_req = '0;
            clear();
        end

        // R4: latch holds after request removed, clear with both still requested keeps it
        hs_req = 3'b010; ls_req = 3'b010;
        step();
        hs_req = 3'b010; ls_req = 3'b000;
        look();
        chk("R4 held off after shoot", gate_hs, 0);
        hs_req = 3'b010; ls_req = 3'b010;
        clear();
        hs_req = 3'b010; ls_req = 3'b000;
        look();
        chk("R4 clear while both requested", gate_hs, 0);
        clear();
        look();
        chk("R4 released by clear", gate_hs, 3'b010);
        chk("R4 flag released", stat_shoot, 0);

        // R5 short delay on channel 0
        hs_req = 3'b001; ls_req = 3'b100; oc_fast = 1'b1;
        oc_cmp = 3'b001;
        repeat (SD - 1) step();
        look();
        chk("R5 short: before expiry", gate_hs, 3'b001);
        step();
        look();
        chk("R5 short: latched off", gate_hs, 3'b000);
        chk("R5 other channel unaffected", gate_ls, 3'b100);
        chk("R5 stat_oc", stat_oc, 1);
        oc_cmp = '0;
        repeat (4) step();
        look();
        chk("R8 stays off without clear", {gate_hs, stat_oc}, 4'b0001);
        clear();
        look();
        chk("R8 released by clear", {gate_hs, stat_oc}, 4'b0010);

        // R6 dropout restarts the count
        oc_cmp = 3'b001;
        repeat (SD - 1) step();
        oc_cmp = '0;
        step();
        oc_cmp = 3'b001;
        repeat (SD - 1) step();
        look();
        chk("R6 restart: still on", gate_hs, 3'b001);
        step();
        look();
        chk("R6 restart: off after full delay", gate_hs, 3'b000);
        oc_cmp = '0;
        clear();

        // R7 long delay selected at start, later select change ignored
        oc_fast = 1'b0;
        oc_cmp = 3'b001;
        step();
        oc_fast = 1'b1;
        repeat (LD - 2) step();
        look();
        chk("R7 frozen long delay: still on", gate_hs, 3'b001);
        step();
        look();
        chk("R7 long delay expiry (R5 long)", gate_hs, 3'b000);
        oc_cmp = '0;
        clear();

        // R9 overvoltage
        hs_req = 3'b101; ls_req = 3'b010; ov_lock_en = 1'b1;
        ov_flag = 1'b1;
        look();
        chk("R9 lockout gates", {gate_hs, gate_ls}, 0);
        step();
        ov_flag = 1'b0;
        look();
        chk("R9 recovery restores", {gate_hs, gate_ls}, {3'b101, 3'b010});
        chk("R9 psf sticky", stat_psf, 1);
        clear();
        look();
        chk("R9 psf cleared", stat_psf, 0);
        ov_lock_en = 1'b0;
        ov_flag = 1'b1;
        look();
        chk("R9 no lockout when disabled", {gate_hs, gate_ls}, {3'b101, 3'b010});
        step();
        ov_flag = 1'b0;
        look();
        chk("R9 psf set without lockout", stat_psf, 1);
        clear();

        // R10 undervoltage
        uv_flag = 1'b1;
        look();
        chk("R10 uv gates", {gate_hs, gate_ls}, 0);
        step();
        uv_flag = 1'b0;
        look();
        chk("R10 psf", stat_psf, 1);
        clear();

        // R11 thermal warning
        tw_cmp = 3'b010;
        step();
        look();
        chk("R11 tw flag", stat_tw, 1);
        chk("R11 gates unchanged", {gate_hs, gate_ls}, {3'b101, 3'b010});
        clear();
        look();
        chk("R11 clear while warm", stat_tw, 1);
        tw_cmp = '0;
        step();
        look();
        chk("R11 sticky after cooling", stat_tw, 1);
        clear();
        look();
        chk("R11 cleared", stat_tw, 0);

        // R12 thermal shutdown
        tsd_cmp = 3'b100;
        look();
        chk("R12 immediate off", {gate_hs, gate_ls}, 0);
        clear();
        tsd_cmp = '0;
        look();
        chk("R12 clear while hot ignored", {gate_hs, gate_ls}, 0);
        step();
        look();
        chk("R12 latched after cooling", {gate_hs, gate_ls}, 0);
        clear();
        look();
        chk("R12 released", {gate_hs, gate_ls}, {3'b101, 3'b010});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule